// File: doc/BRIEF.md
# Zero-Hardwired Bypassed Register File

This block is the integer register file of a small in-order core. It stores 32 words of 32 bits. Two read ports return data combinationally from their addresses, and one write port updates a register at the rising clock edge when its enable is high. Index zero is a constant: it always reads as zero and is never written.

Inside the block, a write forwards to any read port that addresses the same register in the same cycle. A single-edge design therefore behaves as if the write happened in the first half of the cycle and the read in the second half. A pipeline can then hand a result to a dependent instruction in the same cycle, with no forwarding path of its own. The zero rule outranks the forwarding path, so a write aimed at index zero is invisible everywhere.

Register contents are not cleared by reset. While reset is asserted, the write port is held off, so no write lands and no write is forwarded.

Top module: `zrf_top`

## Requirements
- R1: A value written to a nonzero index with the write enable high is returned by either read port in every later cycle, until that index is written again.
- R2: A read port's data follows its address within the same cycle, without waiting for a clock edge.
- R3: A register changes only at a rising clock edge at which the write enable is high and the write address selects it.
- R4: A read of index 0 on either port returns 32'h0000_0000.
- R5: A write with address 0 stores nothing and is not forwarded: both in the same cycle and afterwards, reads of index 0 return zero.
- R6: When the write enable is high and the nonzero write address equals a read address, that read port returns the write data in the same cycle.
- R7: When the write enable is low, a read port addressing the same index as the write address returns the stored value, not the write data.
- R8: Both read ports may address the same register, and both then return the same value, including when both take the forwarded write data.
- R9: While the active-low reset is low, writes are ignored and not forwarded, and register contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect at the rising edge |
| rst_n | input | 1 | Active-low reset; blocks the write port while low |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Destination register index |
| wr_data | input | 32 | Data to write |
| rd0_addr | input | 5 | Read port 0 register index |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 5 | Read port 1 register index |
| rd1_data | output | 32 | Read port 1 data |

## Verification
The assertions assume that every input is driven to a known value whenever reset is high. They also assume that a register's stored value means something only after that register has been written, which is why the landing check looks only at the register written in the previous cycle. The stimulus reads only indices it has already written, or index zero, and changes inputs at the falling clock edge. It therefore never depends on power-up contents or on the order of events at the active edge.

// File: rtl/zrf_pkg.sv
package zrf_pkg;
    // Default geometry of the register file
    localparam int unsigned ZRF_REGS   = 32;
    localparam int unsigned ZRF_DATA_W = 32;
    localparam int unsigned ZRF_ADDR_W = $clog2(ZRF_REGS);
    localparam int unsigned ZRF_RD_PORTS = 2;

    // True when an index names the hardwired zero register
    function automatic logic is_zero_idx(input logic [ZRF_ADDR_W-1:0] idx);
        return (idx == '0);
    endfunction
endpackage

// File: rtl/zrf_wr_qual.sv
// Qualifies the raw write request: reset low or a zero destination kills it.
module zrf_wr_qual #(
    parameter int unsigned ADDR_W = zrf_pkg::ZRF_ADDR_W,
    parameter int unsigned DATA_W = zrf_pkg::ZRF_DATA_W
) (
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wq_en,
    output logic [ADDR_W-1:0] wq_addr,
    output logic [DATA_W-1:0] wq_data
);
    always_comb begin
        wq_en   = rst_n && wr_en && (wr_addr != '0);
        wq_addr = wr_addr;
        wq_data = wr_data;
    end
endmodule

// File: rtl/zrf_store.sv
// Storage for indices 1..REGS-1; index 0 has no flops at all.
module zrf_store #(
    parameter int unsigned REGS   = zrf_pkg::ZRF_REGS,
    parameter int unsigned DATA_W = zrf_pkg::ZRF_DATA_W,
    localparam int unsigned ADDR_W = $clog2(REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wq_en,
    input  logic [ADDR_W-1:0]                wq_addr,
    input  logic [DATA_W-1:0]                wq_data,
    output logic [REGS-1:1][DATA_W-1:0]      regs_o
);
    typedef struct packed {
        logic [REGS-1:1][DATA_W-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wq_en && (wq_addr != '0)) begin
            st_d.regs[wq_addr] = wq_data;
        end
    end

    // Contents carry no reset value by design
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs_o = st_q.regs;

    // R3: without a qualified write no register moves
    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wq_en |=> $stable(st_q));

    // R1: a qualified write is found in its register one edge later
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wq_en |=> (st_q.regs[$past(wq_addr)] == $past(wq_data)));
endmodule

// File: rtl/zrf_rd_port.sv
// One combinational read port: zero index first, then same-cycle forward, then storage.
module zrf_rd_port #(
    parameter int unsigned REGS   = zrf_pkg::ZRF_REGS,
    parameter int unsigned DATA_W = zrf_pkg::ZRF_DATA_W,
    localparam int unsigned ADDR_W = $clog2(REGS)
) (
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [REGS-1:1][DATA_W-1:0] regs_i,
    input  logic                        wq_en,
    input  logic [ADDR_W-1:0]           wq_addr,
    input  logic [DATA_W-1:0]           wq_data,
    output logic [DATA_W-1:0]           rd_data
);
    logic hit_zero;
    logic hit_fwd;

    always_comb begin
        hit_zero = zrf_pkg::is_zero_idx(rd_addr);
        hit_fwd  = wq_en && (wq_addr == rd_addr);
        if (hit_zero) begin
            rd_data = '0;
        end else if (hit_fwd) begin
            rd_data = wq_data;
        end else begin
            rd_data = regs_i[rd_addr];
        end
    end
endmodule

// File: rtl/zrf_top.sv
module zrf_top #(
    parameter int unsigned REGS   = zrf_pkg::ZRF_REGS,
    parameter int unsigned DATA_W = zrf_pkg::ZRF_DATA_W,
    localparam int unsigned ADDR_W = $clog2(REGS),
    localparam int unsigned NRD    = zrf_pkg::ZRF_RD_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_data
);
    logic                        wq_en;
    logic [ADDR_W-1:0]           wq_addr;
    logic [DATA_W-1:0]           wq_data;
    logic [REGS-1:1][DATA_W-1:0] regs_w;
    logic [NRD-1:0][ADDR_W-1:0]  rd_addr_w;
    logic [NRD-1:0][DATA_W-1:0]  rd_data_w;

    zrf_wr_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qual (
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wq_en   (wq_en),
        .wq_addr (wq_addr),
        .wq_data (wq_data)
    );

    zrf_store #(.REGS(REGS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wq_en   (wq_en),
        .wq_addr (wq_addr),
        .wq_data (wq_data),
        .regs_o  (regs_w)
    );

    assign rd_addr_w[0] = rd0_addr;
    assign rd_addr_w[1] = rd1_addr;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        zrf_rd_port #(.REGS(REGS), .DATA_W(DATA_W)) u_port (
            .rd_addr (rd_addr_w[p]),
            .regs_i  (regs_w),
            .wq_en   (wq_en),
            .wq_addr (wq_addr),
            .wq_data (wq_data),
            .rd_data (rd_data_w[p])
        );
    end

    assign rd0_data = rd_data_w[0];
    assign rd1_data = rd_data_w[1];

    // R4: index zero reads zero on both ports
    assert_zero_read0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_addr == '0) |-> (rd0_data == '0));
    assert_zero_read1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_addr == '0) |-> (rd1_data == '0));

    // R5: a write aimed at index zero leaves the storage untouched
    assert_zero_dest_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == '0)) |=> $stable(regs_w));

    // R6: same-cycle forward of a live nonzero write
    assert_forward0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != '0) && (wr_addr == rd0_addr)) |-> (rd0_data == wr_data));
    assert_forward1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != '0) && (wr_addr == rd1_addr)) |-> (rd1_data == wr_data));

    // R8: two ports on one index agree
    assert_ports_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_addr == rd1_addr) |-> (rd0_data == rd1_data));
endmodule

// File: tb/tb_zrf_top.sv
module tb_zrf_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [4:0]  rd0_addr;
    logic [31:0] rd0_data;
    logic [4:0]  rd1_addr;
    logic [31:0] rd1_data;

    always #10 clk = ~clk; // 50 MHz

    zrf_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd0_addr (rd0_addr),
        .rd0_data (rd0_data),
        .rd1_addr (rd1_addr),
        .rd1_data (rd1_data)
    );

    typedef struct {
        string       tag;
        int          port;
        logic [31:0] exp;
    } item_t;

    item_t       sb_q[$];
    event        chk_ev;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    logic [31:0] shadow [32];

    function automatic logic [31:0] pat(input int i, input int salt);
        return {i[7:0], salt[7:0], ~i[7:0], i[7:0] ^ salt[7:0] ^ 8'h5A};
    endfunction

    // Reference read from the requirements
    function automatic logic [31:0] model(input logic [4:0] a);
        if (a == 5'd0) return 32'h0;                                        // R4, R5
        if (rst_n && wr_en && wr_addr != 5'd0 && wr_addr == a) return wr_data; // R6, R9
        return shadow[a];                                                   // R1, R7
    endfunction

    task automatic push_both(input string t0, input string t1);
        item_t a;
        item_t b;
        a.tag = t0; a.port = 0; a.exp = model(rd0_addr);
        b.tag = t1; b.port = 1; b.exp = model(rd1_addr);
        sb_q.push_back(a);
        sb_q.push_back(b);
        -> chk_ev;
    endtask

    task automatic step(input logic rn, input logic [4:0] a0, input logic [4:0] a1,
                        input logic we, input logic [4:0] wa, input logic [31:0] wd,
                        input string t0, input string t1);
        @(negedge clk);
        rst_n = rn; rd0_addr = a0; rd1_addr = a1;
        wr_en = we; wr_addr = wa; wr_data = wd;
        push_both(t0, t1);
        @(posedge clk);
        if (rn && we && wa != 5'd0) shadow[wa] = wd;
    endtask

    // Monitor: pops expectations and compares with the ports
    initial begin
        forever begin
            @(chk_ev);
            #2;
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = (it.port == 0) ? rd0_data : rd1_data;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s port%0d actual %h expected %h", it.tag, it.port, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd0_addr = '0; rd1_addr = '0;
        foreach (shadow[k]) shadow[k] = 32'h0;

        // Reset state: index zero reads zero (R4)
        step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, "R4", "R4");
        step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, "R4", "R4");

        // Fill: port0 forwards the live write (R6), port1 reads last cycle's (R1)
        for (int i = 1; i < 32; i++)
            step(1'b1, 5'(i), 5'(i - 1), 1'b1, 5'(i), pat(i, 1), "R6", "R1");

        // Disabled write to the read index: no forward, nothing changes (R7, R3)
        for (int i = 1; i < 32; i++)
            step(1'b1, 5'(i), 5'(32 - i), 1'b0, 5'(i), ~pat(i, 1), "R7", "R3");

        // Write to index zero is dropped and not forwarded (R5)
        step(1'b1, 5'd0, 5'd0, 1'b1, 5'd0, 32'hDEAD_BEEF, "R5", "R5");
        step(1'b1, 5'd0, 5'd5, 1'b0, 5'd0, 32'h0, "R5", "R1");

        // Both ports on one register, forwarded then stored (R8)
        step(1'b1, 5'd9, 5'd9, 1'b1, 5'd9, pat(9, 2), "R8", "R8");
        step(1'b1, 5'd9, 5'd9, 1'b0, 5'd0, 32'h0, "R8", "R8");

        // Address change mid-cycle without an edge (R2)
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0; rd0_addr = 5'd3; rd1_addr = 5'd4;
        push_both("R2", "R2");
        #5;
        rd0_addr = 5'd7; rd1_addr = 5'd0;
        push_both("R2", "R2");
        #5;
        rd0_addr = 5'd12; rd1_addr = 5'd30;
        push_both("R2", "R2");

        // Writes during reset are ignored and not forwarded (R9)
        step(1'b0, 5'd5, 5'd6, 1'b1, 5'd5, 32'h1234_5678, "R9", "R9");
        step(1'b1, 5'd5, 5'd6, 1'b0, 5'd0, 32'h0, "R9", "R9");

        // Overwrite everything and read back scattered indices (R1, R3)
        for (int i = 1; i < 32; i++)
            step(1'b1, 5'((i * 7) % 32), 5'((i * 13) % 32), 1'b1, 5'(i), pat(i, 3), "R1", "R3");
        step(1'b1, 5'd31, 5'd1, 1'b0, 5'd0, 32'h0, "R1", "R1");

        @(negedge clk);
        #5;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule